// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Linked Buffered Mode

This block is a 16-bit up-counting timer that drives two pulse-width outputs. A prescaler divides the clock by a power of two. The counter runs from zero up to a programmable period value and then wraps. Each channel compares the new count against its own compare value after every counter step. On a match it can force its pin to a chosen level, or toggle it. Each channel can also invert its pin on every counter wrap. When the wrap toggle and a forcing compare are both used, the period register sets the PWM period and the compare register sets the pulse width. Two special settings cover the ends of the duty range: with the wrap toggle off the output settles at 0%, and with the full-duty bit set the output is pinned at 100%.

Channel 0 can also link the pair. In linked mode the channel 0 pin is driven from whichever of the two compare registers is active, and channel 1 goes silent. A new pulse width written into the idle compare register is taken up only at the next counter wrap, so no period is ever cut short.

The block is set up through a simple write port that carries an address and a data word. Its outputs are the two pins, the live count, a one-cycle wrap flag and a one-cycle compare flag for each channel.

Top module: `pwm_pair_timer`

## Requirements
- R1: The reset input is synchronous and active high. During reset and in the first cycle after it, `count`, `pwm_out`, `cmp_flag` and `ovf_flag` are all zero. After reset every channel setting is zero, the period is all ones, the prescale select is 0 and the timer is running.
- R2: Write address 1 holds the period. On each counter step the count rises by one; a step taken while the count is at or above the period returns it to 0. `ovf_flag` is high for exactly one cycle, the cycle in which the count reads 0 after such a wrap. With a period of P and a prescale select of 0, wraps are P+1 cycles apart.
- R3: Bits 4:2 of address 0 select the prescale S. A counter step occurs once every 2^S clock cycles, and any value above 6 acts as 6.
- R4: Address 0 bit 0 is the halt bit: while it is set, the count and the prescaler are frozen. A write to address 0 with bit 1 set clears the count and the prescaler on that edge; no wrap or compare occurs on that edge, and the bit does not stay set.
- R5: The compare values are at address 2 (channel 0) and address 3 (channel 1). On a counter step whose new count equals a channel's active compare value, that channel's `cmp_flag` bit is high for one cycle, provided the channel is enabled.
- R6: The channel settings are at address 4 (channel 0) and address 5 (channel 1). In each, bits 1:0 are the mode: 00 disables the channel and holds its pin and its compare flag at 0; 01 is unbuffered. On channel 0, any mode with bit 1 set is linked mode, so bit 1 takes priority over bit 0. On channel 1, any mode other than 00 is unbuffered.
- R7: Settings bits 3:2 choose the compare action: 10 drives the pin to 0, 11 drives it to 1, 01 toggles it and 00 does nothing. A compare action takes effect ahead of a wrap toggle on the same step.
- R8: With settings bit 4 (wrap toggle) set, the pin inverts on every counter wrap that has no compare action on the same step.
- R9: With the wrap toggle clear and a forcing compare action, the pin settles at the forced level after the first match and stays there (0% duty when the action is 10).
- R10: With settings bit 5 (full duty) and the wrap toggle both set, the pin is held every cycle at the pulse level. The pulse level is 0 for action 11 and 1 for every other action.
- R11: In linked mode the channel 0 settings govern the channel 0 pin, while `pwm_out[1]` and `cmp_flag[1]` stay at 0. The channel 0 compare register is the active source when linking starts.
- R12: In linked mode, a write to the idle compare register becomes the active source at the next counter wrap. That write does not affect the period that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | One-cycle pulse after a counter wrap |
| cmp_flag | output | 2 | One-cycle compare match pulse per channel |
| pwm_out | output | 2 | Channel output pins |

## Verification
Some properties are checked by assertions on every cycle:
- the count is zero whenever the wrap flag is up;
- the count holds while halted;
- a disabled channel stays quiet, and channel 1 stays quiet while linked;
- the full-duty level follows the compare action;
- the linked compare source changes only at a wrap, or when linking ends.

Other behaviour only the bench scenarios can show. These are the duty measured over whole periods, the spacing of wraps at each prescale, the one-period delay of a buffered width change, and the priority of a compare at count zero over the wrap toggle. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int AW  = 3;
  localparam int NCH = 2;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_CMP0   = 3'd2,
    A_CMP1   = 3'd3,
    A_CFG0   = 3'd4,
    A_CFG1   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  typedef struct packed {
    logic      full;
    logic      wrap_tgl;
    cmp_act_e  act;
    logic [1:0] mode;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int PS_W        = 3,
  parameter int DIV_LOG_MAX = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PC_W = DIV_LOG_MAX;

  logic [PS_W-1:0] sel_eff;
  logic [PC_W:0]   span;
  logic [PC_W-1:0] lim;
  logic [PC_W-1:0] pc_q;

  assign sel_eff = (sel > PS_W'(DIV_LOG_MAX)) ? PS_W'(DIV_LOG_MAX) : sel;
  assign span    = (PC_W+1)'(1) << sel_eff;
  assign lim     = span[PC_W-1:0] - PC_W'(1);
  assign tick    = run && (pc_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) pc_q <= '0;
    else if (run)   pc_q <= tick ? '0 : pc_q + PC_W'(1);
  end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] nxt,
  output logic          wrap,
  output logic          ovf_q
);
  logic at_end;

  assign at_end = (cnt_q >= period);
  assign nxt    = at_end ? '0 : cnt_q + CW'(1);
  assign wrap   = step && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (clr)       cnt_q <= '0;
      else if (step) cnt_q <= nxt;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          wrap,
  input  logic [CW-1:0] nxt,
  input  logic [CW-1:0] cmp,
  input  logic          on,
  input  ch_cfg_t       cfg,
  output logic          pin,
  output logic          flag
);
  logic match;
  logic full_lvl;

  assign match    = step && (nxt == cmp);
  assign full_lvl = (cfg.act != ACT_SET);

  always_ff @(posedge clk) begin
    if (rst || !on) begin
      pin  <= 1'b0;
      flag <= 1'b0;
    end else begin
      flag <= match;
      if (cfg.full && cfg.wrap_tgl)
        pin <= full_lvl;
      else if (match && cfg.act != ACT_NONE)
        pin <= (cfg.act == ACT_TOGGLE) ? ~pin : cfg.act[0];
      else if (wrap && cfg.wrap_tgl)
        pin <= ~pin;
    end
  end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CW          = 16,
  parameter int PS_W        = 3,
  parameter int DIV_LOG_MAX = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   count,
  output logic            ovf_flag,
  output logic [NCH-1:0]  cmp_flag,
  output logic [NCH-1:0]  pwm_out
);
  localparam int CFG_W = $bits(ch_cfg_t);

  logic            halt_q;
  logic [PS_W-1:0] ps_q;
  logic [CW-1:0]   period_q;
  logic [CW-1:0]   cmp_q [NCH];
  ch_cfg_t         cfg_q [NCH];

  logic          clr_pulse, tick_raw, tick_e, wrap_tick;
  logic [CW-1:0] nxt_cnt;
  logic          linked, sel_q, pend_q, wr_idle;

  // register file
  assign clr_pulse = wr_en && (wr_addr == A_CTRL) && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q   <= 1'b0;
      ps_q     <= '0;
      period_q <= '1;
      for (int i = 0; i < NCH; i++) begin
        cmp_q[i] <= '0;
        cfg_q[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          halt_q <= wr_data[0];
          ps_q   <= wr_data[2 +: PS_W];
        end
        A_PERIOD: period_q <= wr_data;
        A_CMP0:   cmp_q[0] <= wr_data;
        A_CMP1:   cmp_q[1] <= wr_data;
        A_CFG0:   cfg_q[0] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        A_CFG1:   cfg_q[1] <= ch_cfg_t'(wr_data[CFG_W-1:0]);
        default:  ;
      endcase
    end
  end

  // time base
  pwm_prescale #(.PS_W(PS_W), .DIV_LOG_MAX(DIV_LOG_MAX)) u_pre (
    .clk(clk), .rst(rst), .run(!halt_q), .clr(clr_pulse),
    .sel(ps_q), .tick(tick_raw)
  );

  assign tick_e = tick_raw && !clr_pulse;

  pwm_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_pulse), .step(tick_e),
    .period(period_q), .cnt_q(count), .nxt(nxt_cnt),
    .wrap(wrap_tick), .ovf_q(ovf_flag)
  );

  // linked-pair compare source selection
  assign linked  = cfg_q[0].mode[1];
  assign wr_idle = wr_en && (((wr_addr == A_CMP0) && sel_q) ||
                             ((wr_addr == A_CMP1) && !sel_q));

  always_ff @(posedge clk) begin
    if (rst || !linked) begin
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wrap_tick && pend_q) begin
        sel_q  <= ~sel_q;
        pend_q <= 1'b0;
      end
      if (wr_idle) pend_q <= 1'b1;
    end
  end

  // channels
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          ch_on;
    logic [CW-1:0] ch_cmp;
    if (g == 0) begin : g_lead
      assign ch_on  = (cfg_q[0].mode != 2'b00);
      assign ch_cmp = (linked && sel_q) ? cmp_q[1] : cmp_q[0];
    end else begin : g_follow
      assign ch_on  = (cfg_q[g].mode != 2'b00) && !linked;
      assign ch_cmp = cmp_q[g];
    end
    pwm_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .step(tick_e), .wrap(wrap_tick),
      .nxt(nxt_cnt), .cmp(ch_cmp), .on(ch_on), .cfg(cfg_q[g]),
      .pin(pwm_out[g]), .flag(cmp_flag[g])
    );
  end
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk
  import pwm_pair_pkg::*;
#(
  parameter int CW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  count,
  input logic           ovf_flag,
  input logic [NCH-1:0] cmp_flag,
  input logic [NCH-1:0] pwm_out,
  input logic           halt_q,
  input logic           clr_pulse,
  input ch_cfg_t        cfg0,
  input logic           linked,
  input logic           sel_q,
  input logic           wrap_tick
);
  // R2: the wrap flag is only up while the count reads zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (count == '0));

  // R4: halted and not cleared keeps the count
  a_r4_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !clr_pulse) |=> $stable(count));

  // R6: a disabled channel 0 stays low and silent
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg0.mode == 2'b00) |=> (!pwm_out[0] && !cmp_flag[0]));

  // R10: full duty drives the pulse level
  a_r10_full_level: assert property (@(posedge clk) disable iff (rst)
    ((cfg0.mode != 2'b00) && cfg0.full && cfg0.wrap_tgl) |=>
      (pwm_out[0] == $past(cfg0.act != ACT_SET)));

  // R11: channel 1 is silent while the pair is linked
  a_r11_pin1_quiet: assert property (@(posedge clk) disable iff (rst)
    linked |=> (!pwm_out[1] && !cmp_flag[1]));

  // R12: the compare source switches only at a wrap or when linking ends
  a_r12_sel_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> ($past(wrap_tick) || !$past(linked)));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .count(count), .ovf_flag(ovf_flag),
  .cmp_flag(cmp_flag), .pwm_out(pwm_out), .halt_q(halt_q),
  .clr_pulse(clr_pulse), .cfg0(cfg_q[0]), .linked(linked),
  .sel_q(sel_q), .wrap_tick(wrap_tick)
);

// File: tb/pwm_pair_timer_test.sv
`timescale 1ns/1ps
module pwm_pair_timer_test;
  localparam int CW = 16;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count;
  logic ovf_flag;
  logic [1:0] cmp_flag, pwm_out;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pwm_pair_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_halt, m_ps, m_pc, m_cnt, m_per, m_sel, m_pend, m_ovf;
  int m_cmp[2], m_cfg[2], m_pin[2], m_flag[2];

  always @(posedge clk) begin
    if (rst) begin
      m_halt = 0; m_ps = 0; m_pc = 0; m_cnt = 0; m_per = MASK;
      m_sel = 0; m_pend = 0; m_ovf = 0;
      for (int i = 0; i < 2; i++) begin
        m_cmp[i] = 0; m_cfg[i] = 0; m_pin[i] = 0; m_flag[i] = 0;
      end
    end else begin
      int lim, nx, sel_old;
      bit clr, tick, te, wrap, linked;
      clr  = wr_en && wr_addr == 0 && wr_data[1];
      lim  = (1 << ((m_ps > 6) ? 6 : m_ps)) - 1;
      tick = !m_halt && m_pc >= lim;
      te   = tick && !clr;
      wrap = te && m_cnt >= m_per;
      nx   = (m_cnt >= m_per) ? 0 : ((m_cnt + 1) & MASK);
      linked = (m_cfg[0] >> 1) & 1;
      for (int ch = 0; ch < 2; ch++) begin
        bit on, match;
        int cv, act, tg, fu;
        on = (ch == 0) ? ((m_cfg[0] & 3) != 0) : ((m_cfg[1] & 3) != 0 && !linked);
        cv = (ch == 0 && linked && m_sel) ? m_cmp[1] : m_cmp[ch];
        match = te && nx == cv;
        act = (m_cfg[ch] >> 2) & 3; tg = (m_cfg[ch] >> 4) & 1; fu = (m_cfg[ch] >> 5) & 1;
        if (!on) begin m_pin[ch] = 0; m_flag[ch] = 0; end
        else begin
          m_flag[ch] = match;
          if (fu && tg) m_pin[ch] = (act != 3);
          else if (match && act != 0) m_pin[ch] = (act == 1) ? !m_pin[ch] : (act & 1);
          else if (wrap && tg) m_pin[ch] = !m_pin[ch];
        end
      end
      m_ovf = wrap;
      if (clr) m_pc = 0; else if (!m_halt) m_pc = tick ? 0 : m_pc + 1;
      if (clr) m_cnt = 0; else if (te) m_cnt = nx;
      sel_old = m_sel;
      if (!linked) begin m_sel = 0; m_pend = 0; end
      else begin
        if (wrap && m_pend) begin m_sel = !m_sel; m_pend = 0; end
        if (wr_en && ((wr_addr == 2 && sel_old) || (wr_addr == 3 && !sel_old))) m_pend = 1;
      end
      if (wr_en) case (wr_addr)
        0: begin m_halt = wr_data[0]; m_ps = (wr_data >> 2) & 7; end
        1: m_per = wr_data;
        2: m_cmp[0] = wr_data;
        3: m_cmp[1] = wr_data;
        4: m_cfg[0] = wr_data & 63;
        5: m_cfg[1] = wr_data & 63;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk({cur_req, " count"}, count, m_cnt);
      chk({cur_req, " ovf_flag"}, ovf_flag, m_ovf);
      chk({cur_req, " cmp_flag0"}, cmp_flag[0], m_flag[0]);
      chk({cur_req, " cmp_flag1"}, cmp_flag[1], m_flag[1]);
      chk({cur_req, " pwm_out0"}, pwm_out[0], m_pin[0]);
      chk({cur_req, " pwm_out1"}, pwm_out[1], m_pin[1]);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ovf();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ovf_flag) return;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); n++;
      if (ovf_flag) return;
    end
  endtask

  task automatic hi_count(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += pwm_out[ch];
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic flag_count(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += cmp_flag[ch];
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, h, c0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 pins in reset", pwm_out, 0);
    chk("R1 flags in reset", {ovf_flag, cmp_flag}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pins after reset", pwm_out, 0);
    cmp_en = 1'b1;

    cur_req = "R2";
    wr(1, 9); wr(0, 2);
    wait_ovf();
    chk("R2 count zero on wrap", count, 0);
    gap(n); chk("R2 wrap spacing", n, 10);

    cur_req = "R3";
    wr(0, 2 << 2); wait_ovf(); gap(n); chk("R3 prescale 4 spacing", n, 40);
    wr(0, 7 << 2); wait_ovf(); gap(n); chk("R3 prescale select 7 acts as 64", n, 640);
    wr(0, 0);

    cur_req = "R4";
    wr(0, 1); c0 = count;
    repeat (20) @(negedge clk);
    chk("R4 halt freezes count", count, c0);
    wr(0, 2);
    chk("R4 clear zeroes count", count, 0);

    cur_req = "R7 R8";
    wr(2, 4); wr(4, 1 + 8 + 16);
    wait_ovf(); wait_ovf();
    hi_count(0, 100, h); chk("R8 clear-on-compare duty", h, 40);
    cur_req = "R5";
    for (int i = 0; i < 20 && !cmp_flag[0]; i++) @(negedge clk);
    chk("R5 flag at compare count", count, 4);
    cur_req = "R7 R8";
    wr(3, 6); wr(5, 1 + 12 + 16);
    wait_ovf(); wait_ovf();
    hi_count(1, 100, h); chk("R7 set-on-compare duty ch1", h, 40);

    wr(2, 0);
    wait_ovf(); wait_ovf();
    hi_count(0, 30, h); chk("R7 compare beats wrap toggle", h, 0);
    wr(2, 4); wr(4, 1 + 4);
    wait_ovf(); wait_ovf();
    hi_count(0, 20, h); chk("R7 toggle action half duty", h, 10);

    cur_req = "R9";
    wr(4, 1 + 8);
    wait_ovf(); wait_ovf();
    hi_count(0, 30, h); chk("R9 zero duty", h, 0);

    cur_req = "R10";
    wr(4, 1 + 8 + 16 + 32);
    wait_ovf();
    hi_count(0, 30, h); chk("R10 full duty high", h, 30);
    wr(4, 1 + 12 + 16 + 32);
    wait_ovf();
    hi_count(0, 30, h); chk("R10 full duty low level", h, 0);

    cur_req = "R6";
    wr(4, 8 + 16);
    wait_ovf();
    hi_count(0, 30, h); chk("R6 off pin low", h, 0);
    flag_count(0, 30, h); chk("R6 off no flag", h, 0);

    cur_req = "R11 R12";
    wr(2, 3); wr(4, 2 + 8 + 16);
    wait_ovf(); wait_ovf();
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd7;
    hi_count(0, 10, h); chk("R12 width held in current period", h, 3);
    hi_count(0, 10, h); chk("R12 new width after wrap", h, 7);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd5;
    hi_count(0, 10, h); chk("R12 second change held", h, 7);
    hi_count(0, 10, h); chk("R12 second change applied", h, 5);
    hi_count(1, 30, h); chk("R11 linked ch1 pin low", h, 0);
    flag_count(1, 30, h); chk("R11 linked ch1 no flag", h, 0);

    cmp_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule